// File: doc/BRIEF.md
# Superframe overhead bit inserter

This block holds the transmit values of the M4, M5 and M6 maintenance channels of a digital subscriber line framer. Once per superframe it presents them to the line framer as one parallel word. A CPU writes two small registers through a simple register port. At each superframe-start strobe, the block takes a copy of those registers, merges in the live activation bits, and holds the result steady on its outputs until the next strobe. The framer therefore never sees a superframe that mixes old and new values.

Three M4 positions belong to the activation state machine, so the register bits at those positions are not used. The act bit and the uoa/sai bit are always taken from the activation inputs. The dea bit is taken from them only in line-termination (LT) mode. When these positions are read back, the register port returns the values actually on the line in the current superframe. In network-termination (NT) mode, one M4 position carries the cold-start flag. It is sent as 0 unless the CPU has explicitly written it to 1. The far-end block error (febe) bit normally follows the local CRC check result. The CPU can force febe to 0 for exactly one superframe. After that superframe has been sent, the request clears itself.

Top module: `oh_inserter`

## Requirements
- R1: After reset, oh_m4 is 0x7D, oh_m56 is 0xF and oh_load is 0. Reading select 0 (M4) returns 0x7D and reading select 1 (M56) returns 0x1F.
- R2: A write with reg_sel=0 stores reg_wdata as the M4 register, and a write with reg_sel=1 stores reg_wdata[4:0] as the M56 register. The read data appears on reg_rdata one clock after reg_sel is presented. M4 bits 5, 4, 2 and 0, and bit 6 in NT mode, read back as written. The M56 register reads back zero-extended.
- R3: In the word latched at a strobe, oh_m4[7] equals act_in and oh_m4[1] equals uoa_sai_in. When lt_mode=1, oh_m4[6] equals dea_in. Register bits at those positions have no effect on them.
- R4: M4 readback bits 7 and 1, and bit 6 when lt_mode=1, show the values in the current oh_m4 word, not the register or the present activation inputs.
- R5: oh_m4 and oh_m56 change only in the cycle after sf_start. Register writes and input changes between strobes leave them unchanged.
- R6: When lt_mode=0, oh_m4[3] (cold-start flag) is 0 after reset and otherwise equals bit 3 of the last M4 write. When lt_mode=1, oh_m4[3] equals register bit 3.
- R7: oh_m56[3:1] carries the M56 register bits 4, 3 and 2 (M5 first spare, M6 spare, M5 second spare), latched at the strobe.
- R8: oh_m56[0] is febe. At a strobe it is 0 if febe_force_en=1 and either M56 register bit 1 or bit 0 is 0. Otherwise it equals crc_ok.
- R9: A strobe that sends a forced febe returns M56 register bits 1:0 to 11. The next strobe sends crc_ok again.
- R10: With febe_force_en=0, a 0 in M56 bits 1:0 does not force febe, and the bits keep their written value.
- R11: oh_load is 1 for exactly the one cycle after each strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write enable |
| reg_sel | input | 1 | Register select for write and read: 0 = M4, 1 = M56 |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| sf_start | input | 1 | Superframe-start strobe |
| lt_mode | input | 1 | 1 = line-termination mode, 0 = network-termination mode |
| act_in | input | 1 | Activation act bit |
| dea_in | input | 1 | Activation dea bit (used in LT mode) |
| uoa_sai_in | input | 1 | Activation uoa/sai bit |
| febe_force_en | input | 1 | Enables forcing febe through the M56 control bits |
| crc_ok | input | 1 | Local CRC check result, the normal febe value |
| oh_m4 | output | 8 | M4 word for the current superframe |
| oh_m56 | output | 4 | {m51, m61, m52, febe} for the current superframe |
| oh_load | output | 1 | Pulses when a new overhead word is presented |

## Verification
The bench builds the block with its default widths: an 8-bit M4 register, a 5-bit M56 register and two febe control bits. These widths make a full sweep practical. Every one of the 256 M4 codes is written and strobed in both modes, with the activation inputs set against the written bits. The inputs are then changed after the strobe, which separates the transmitted values from both the register and the live inputs. All 32 M56 codes are run against both crc_ok values, with forcing enabled and disabled, and a second strobe follows each one to observe the self-clearing of the febe request.

// File: rtl/oh_pkg.sv
package oh_pkg;

  typedef enum logic {
    SEL_M4  = 1'b0,
    SEL_M56 = 1'b1
  } oh_sel_e;

  typedef struct packed {
    logic act;
    logic dea;
    logic uoa_sai;
  } act_bits_t;

endpackage

// File: rtl/oh_regs.sv
module oh_regs
  import oh_pkg::*;
#(
  parameter int M4_W    = 8,
  parameter int M56_W   = 5,
  parameter int FEBX_W  = 2,
  parameter logic [M4_W-1:0]  RST_M4  = 8'h7D,
  parameter logic [M56_W-1:0] RST_M56 = 5'h1F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [M4_W-1:0]   wr_data,
  input  logic              sf_start,
  input  logic              force_en,
  output logic [M4_W-1:0]   m4_q,
  output logic [M56_W-1:0]  m56_q,
  output logic              cs0_set,
  output logic              force_pend
);
  localparam int CS0_POS = 3;

  logic wr_m4, wr_m56, restore;

  assign wr_m4      = wr_en && (wr_sel == SEL_M4);
  assign wr_m56     = wr_en && (wr_sel == SEL_M56);
  assign force_pend = force_en && (m56_q[FEBX_W-1:0] != {FEBX_W{1'b1}});
  assign restore    = sf_start && force_pend && !wr_m56;

  always_ff @(posedge clk) begin
    if (rst) begin
      m4_q    <= RST_M4;
      m56_q   <= RST_M56;
      cs0_set <= 1'b0;
    end else begin
      if (wr_m4) begin
        m4_q    <= wr_data;
        cs0_set <= wr_data[CS0_POS];
      end
      if (wr_m56) begin
        m56_q <= wr_data[M56_W-1:0];
      end else if (restore) begin
        m56_q[FEBX_W-1:0] <= {FEBX_W{1'b1}};
      end
    end
  end

  // R2: a write lands in the selected register
  a_r2_m4_write: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && wr_sel == SEL_M4 && !rst) |-> m4_q == $past(wr_data));

  // R9: a forced febe request clears itself once sent
  a_r9_self_restore: assert property (@(posedge clk) disable iff (rst)
    $past(sf_start && force_pend && !(wr_en && wr_sel == SEL_M56) && !rst)
      |-> m56_q[FEBX_W-1:0] == {FEBX_W{1'b1}});

  // R10: without the enable, control bits are not touched by a strobe
  a_r10_no_touch: assert property (@(posedge clk) disable iff (rst)
    $past(!force_en && !wr_en && !rst) |-> $stable(m56_q));

endmodule

// File: rtl/oh_frame_out.sv
module oh_frame_out
  import oh_pkg::*;
#(
  parameter int M4_W   = 8,
  parameter int M56_W  = 5,
  parameter int FEBX_W = 2,
  parameter logic [M4_W-1:0]  RST_M4  = 8'h7D,
  parameter logic [M56_W-1:0] RST_M56 = 5'h1F,
  localparam int OUT56_W = M56_W - FEBX_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sf_start,
  input  logic               lt_mode,
  input  act_bits_t          act_bits,
  input  logic [M4_W-1:0]    m4_q,
  input  logic [M56_W-1:0]   m56_q,
  input  logic               cs0_set,
  input  logic               force_pend,
  input  logic               crc_ok,
  output logic [M4_W-1:0]    oh_m4,
  output logic [OUT56_W-1:0] oh_m56,
  output logic               oh_load
);
  localparam int ACT_POS = M4_W - 1;
  localparam int DEA_POS = M4_W - 2;
  localparam int UOA_POS = 1;
  localparam int CS0_POS = 3;

  logic [M4_W-1:0]    m4_next;
  logic [OUT56_W-1:0] m56_next;

  always_comb begin
    m4_next          = m4_q;
    m4_next[ACT_POS] = act_bits.act;
    m4_next[UOA_POS] = act_bits.uoa_sai;
    if (lt_mode) m4_next[DEA_POS] = act_bits.dea;
    else         m4_next[CS0_POS] = cs0_set;
    m56_next = {m56_q[M56_W-1:FEBX_W], force_pend ? 1'b0 : crc_ok};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oh_m4   <= RST_M4;
      oh_m56  <= {RST_M56[M56_W-1:FEBX_W], 1'b1};
      oh_load <= 1'b0;
    end else begin
      oh_load <= sf_start;
      if (sf_start) begin
        oh_m4  <= m4_next;
        oh_m56 <= m56_next;
      end
    end
  end

  // R3: activation positions come from the activation inputs
  a_r3_act_bit: assert property (@(posedge clk) disable iff (rst)
    $past(sf_start && !rst) |-> oh_m4[ACT_POS] == $past(act_bits.act));
  a_r3_uoa_bit: assert property (@(posedge clk) disable iff (rst)
    $past(sf_start && !rst) |-> oh_m4[UOA_POS] == $past(act_bits.uoa_sai));
  a_r3_dea_lt: assert property (@(posedge clk) disable iff (rst)
    $past(sf_start && lt_mode && !rst) |-> oh_m4[DEA_POS] == $past(act_bits.dea));

  // R5: nothing moves between strobes
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    $past(!sf_start) |-> $stable(oh_m4) && $stable(oh_m56));

  // R8: a pending force puts febe to 0
  a_r8_febe_forced: assert property (@(posedge clk) disable iff (rst)
    $past(sf_start && force_pend && !rst) |-> !oh_m56[0]);

  // R11: load pulse marks each new word
  a_r11_load: assert property (@(posedge clk) disable iff (rst)
    oh_load |-> $past(sf_start));

endmodule

// File: rtl/oh_readback.sv
module oh_readback
  import oh_pkg::*;
#(
  parameter int M4_W  = 8,
  parameter int M56_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_sel,
  input  logic             lt_mode,
  input  logic [M4_W-1:0]  m4_q,
  input  logic [M56_W-1:0] m56_q,
  input  logic [M4_W-1:0]  oh_m4,
  output logic [M4_W-1:0]  rd_data
);
  localparam int ACT_POS = M4_W - 1;
  localparam int DEA_POS = M4_W - 2;
  localparam int UOA_POS = 1;

  logic [M4_W-1:0] m4_view;

  always_comb begin
    m4_view          = m4_q;
    m4_view[ACT_POS] = oh_m4[ACT_POS];
    m4_view[UOA_POS] = oh_m4[UOA_POS];
    if (lt_mode) m4_view[DEA_POS] = oh_m4[DEA_POS];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_sel == SEL_M4) rd_data <= m4_view;
    else rd_data <= {{(M4_W-M56_W){1'b0}}, m56_q};
  end

  // R4: readback of the act position tracks the transmitted word
  a_r4_act_view: assert property (@(posedge clk) disable iff (rst)
    $past(rd_sel == SEL_M4 && !rst) |-> rd_data[ACT_POS] == $past(oh_m4[ACT_POS]));

endmodule

// File: rtl/oh_inserter.sv
module oh_inserter
  import oh_pkg::*;
#(
  parameter int M4_W   = 8,
  parameter int M56_W  = 5,
  parameter int FEBX_W = 2,
  parameter logic [M4_W-1:0]  RST_M4  = 8'h7D,
  parameter logic [M56_W-1:0] RST_M56 = 5'h1F,
  localparam int OUT56_W = M56_W - FEBX_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_sel,
  input  logic [M4_W-1:0]    reg_wdata,
  output logic [M4_W-1:0]    reg_rdata,
  input  logic               sf_start,
  input  logic               lt_mode,
  input  logic               act_in,
  input  logic               dea_in,
  input  logic               uoa_sai_in,
  input  logic               febe_force_en,
  input  logic               crc_ok,
  output logic [M4_W-1:0]    oh_m4,
  output logic [OUT56_W-1:0] oh_m56,
  output logic               oh_load
);
  logic [M4_W-1:0]  m4_q;
  logic [M56_W-1:0] m56_q;
  logic             cs0_set, force_pend;
  act_bits_t        act_bits;

  assign act_bits = '{act: act_in, dea: dea_in, uoa_sai: uoa_sai_in};

  oh_regs #(
    .M4_W(M4_W), .M56_W(M56_W), .FEBX_W(FEBX_W),
    .RST_M4(RST_M4), .RST_M56(RST_M56)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .wr_sel(reg_sel),
    .wr_data(reg_wdata), .sf_start(sf_start), .force_en(febe_force_en),
    .m4_q(m4_q), .m56_q(m56_q), .cs0_set(cs0_set), .force_pend(force_pend)
  );

  oh_frame_out #(
    .M4_W(M4_W), .M56_W(M56_W), .FEBX_W(FEBX_W),
    .RST_M4(RST_M4), .RST_M56(RST_M56)
  ) u_out (
    .clk(clk), .rst(rst), .sf_start(sf_start), .lt_mode(lt_mode),
    .act_bits(act_bits), .m4_q(m4_q), .m56_q(m56_q), .cs0_set(cs0_set),
    .force_pend(force_pend), .crc_ok(crc_ok),
    .oh_m4(oh_m4), .oh_m56(oh_m56), .oh_load(oh_load)
  );

  oh_readback #(
    .M4_W(M4_W), .M56_W(M56_W)
  ) u_rb (
    .clk(clk), .rst(rst), .rd_sel(reg_sel), .lt_mode(lt_mode),
    .m4_q(m4_q), .m56_q(m56_q), .oh_m4(oh_m4), .rd_data(reg_rdata)
  );

endmodule

// File: tb/test_oh_inserter.sv
`timescale 1ns/1ps
module test_oh_inserter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0, reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       sf_start = 1'b0, lt_mode = 1'b0;
  logic       act_in = 1'b0, dea_in = 1'b0, uoa_sai_in = 1'b0;
  logic       febe_force_en = 1'b0, crc_ok = 1'b1;
  logic [7:0] oh_m4;
  logic [3:0] oh_m56;
  logic       oh_load;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  oh_inserter i_oh_inserter (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sf_start(sf_start),
    .lt_mode(lt_mode), .act_in(act_in), .dea_in(dea_in),
    .uoa_sai_in(uoa_sai_in), .febe_force_en(febe_force_en), .crc_ok(crc_ok),
    .oh_m4(oh_m4), .oh_m56(oh_m56), .oh_load(oh_load)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic s, logic [7:0] d);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic strobe();
    sf_start = 1'b1;
    tick();
    sf_start = 1'b0;
  endtask

  task automatic rd(logic s);
    reg_sel = s;
    tick();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] prev4;
    repeat (3) tick();
    rst = 1'b0;
    // R1: reset state
    check("R1 oh_m4", oh_m4, 8'h7D);
    check("R1 oh_m56", {4'h0, oh_m56}, 8'h0F);
    check("R1 oh_load", {7'h0, oh_load}, 8'h00);
    rd(1'b0); check("R1 rd m4", reg_rdata, 8'h7D);
    rd(1'b1); check("R1 rd m56", reg_rdata, 8'h1F);

    // R6: NT cold-start flag is 0 until written, though register bit 3 is 1
    lt_mode = 1'b0; act_in = 1'b1; uoa_sai_in = 1'b0;
    strobe();
    check("R6 cs0 default", oh_m4, 8'hF5);
    check("R11 load pulse", {7'h0, oh_load}, 8'h01);
    tick();
    check("R11 load drops", {7'h0, oh_load}, 8'h00);
    prev4 = oh_m4;

    // R2..R6, R11: full M4 sweep in both modes
    for (int m = 0; m < 2; m++) begin
      lt_mode = m[0];
      for (int v = 0; v < 256; v++) begin
        logic [7:0] w, e, rb;
        logic a, d, u;
        w = v[7:0];
        wr(1'b0, w);
        a = ~w[7] ^ w[4]; d = ~w[6] ^ w[5]; u = ~w[1] ^ w[2];
        act_in = a; dea_in = d; uoa_sai_in = u;
        tick();
        check("R5 hold before strobe", oh_m4, prev4);
        strobe();
        e = w; e[7] = a; e[1] = u;
        if (lt_mode) e[6] = d;
        check("R3 R6 oh_m4", oh_m4, e);
        check("R11 load", {7'h0, oh_load}, 8'h01);
        act_in = ~a; dea_in = ~d; uoa_sai_in = ~u;
        rb = w; rb[7] = e[7]; rb[1] = e[1];
        if (lt_mode) rb[6] = e[6];
        rd(1'b0);
        check("R2 R4 readback", reg_rdata, rb);
        check("R5 hold after input change", oh_m4, e);
        prev4 = e;
      end
    end

    // R7..R10: M56 sweep
    lt_mode = 1'b0;
    for (int en = 0; en < 2; en++) begin
      for (int c = 0; c < 2; c++) begin
        for (int v = 0; v < 32; v++) begin
          logic [4:0] w;
          logic pend;
          w = v[4:0];
          wr(1'b1, {3'b000, w});
          crc_ok = c[0]; febe_force_en = en[0];
          pend = en[0] && (w[1:0] != 2'b11);
          strobe();
          check("R7 R8 oh_m56", {4'h0, oh_m56}, {4'h0, w[4:2], pend ? 1'b0 : c[0]});
          rd(1'b1);
          check("R9 R10 febe ctl readback", reg_rdata,
                {3'b000, w[4:2], pend ? 2'b11 : w[1:0]});
          strobe();
          check("R9 R10 febe after", {4'h0, oh_m56}, {4'h0, w[4:2], c[0]});
        end
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule